// File: doc/BRIEF.md
# Tuning Clock-Gating Sequencer

This block wraps every tuning command and every manual change of the sampling tap in a fixed, glitch-safe sequence. The delay trimmer must never have its input clock running while its tap moves. When a request pulse arrives, the block records whether the card clock was on and turns it off. It then issues a one-cycle go pulse, which lets the command or tap update go through. After that it waits a settling time of one microsecond, counted in core clock cycles. It then pulses a reset to the command and data paths. Finally it puts the card clock back into the state it had when the request arrived, and signals completion with a one-cycle done pulse.

While no sequence is running, the card clock enable output follows the enable input with one register stage. A request that arrives while a sequence is in progress has no effect. A request that arrives in the cycle where done is high starts a new sequence.

Top module: `tune_gate_seq`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `card_clk_en_o`, `go_o`, `path_rst_o` and `done_o` are all 0.
- R2: While no sequence is active and `req_i` is low, `card_clk_en_o` equals the value `clk_en_i` had at the previous clock edge.
- R3: The first clock edge that samples an accepted `req_i` drives `card_clk_en_o` to 0. It stays 0 until the sequence restores it.
- R4: `go_o` is high for exactly one cycle, starting one clock edge after the request was accepted, and the card clock is off while it is high.
- R5: `path_rst_o` is high for exactly one cycle. It rises exactly `CYC_PER_US` clock edges after `go_o` rose, and the card clock is off while it is high.
- R6: `done_o` is high for exactly one cycle, starting one edge after `path_rst_o`. In that same cycle `card_clk_en_o` is restored to the `clk_en_i` value sampled with the request.
- R7: If `clk_en_i` was 0 when the request was accepted, `card_clk_en_o` is still 0 in the done cycle.
- R8: A `req_i` pulse that arrives after acceptance and before the done cycle produces no additional `go_o`, `path_rst_o` or `done_o` pulse.
- R9: A `req_i` that is high in the done cycle is accepted. The next cycle shows the card clock gated again, and `go_o` follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request to run the gate/update/settle/reset sequence |
| clk_en_i | input | 1 | Current card clock enable wanted by the host |
| card_clk_en_o | output | 1 | Registered card clock enable toward the clock gate |
| go_o | output | 1 | One-cycle pulse: send the tuning command or apply the tap |
| path_rst_o | output | 1 | One-cycle reset pulse for the command and data paths |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the handover at the end of a sequence. There, a new request coincides with the done pulse, and the saved enable of one sequence must not leak into the next. The stimulus raises `req_i` exactly in the done cycle, right after sampling it. The first sequence uses a saved enable of 1 and the second uses 0, so a stale capture would show on the restored clock. A second point of interest is a request injected partway through the settling count. The count and pulse positions are checked edge by edge, so any restart or extra pulse is seen.

// File: rtl/tune_gate_pkg.sv
`timescale 1ns/1ps
package tune_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_WAIT = 2'd2,
    ST_RST  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tune_settle_timer.sv
`timescale 1ns/1ps
module tune_settle_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hit
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hit = run_q && (cnt_q == '0);
endmodule

// File: rtl/tune_clk_hold.sv
`timescale 1ns/1ps
module tune_clk_hold (
  input  logic clk,
  input  logic rst,
  input  logic track,
  input  logic capture,
  input  logic restore,
  input  logic clk_en_i,
  output logic clk_en_o
);
  logic saved_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (capture) begin
        saved_q <= clk_en_i;
        en_q    <= 1'b0;
      end else if (restore) begin
        en_q    <= saved_q;
      end else if (track) begin
        en_q    <= clk_en_i;
      end
    end
  end

  assign clk_en_o = en_q;
endmodule

// File: rtl/tune_seq_fsm.sv
`timescale 1ns/1ps
module tune_seq_fsm
  import tune_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic timer_hit,
  output logic timer_start,
  output logic track,
  output logic capture,
  output logic restore,
  output logic go_o,
  output logic path_rst_o,
  output logic done_o
);
  seq_state_t state_q;
  logic go_q, prst_q, done_q;

  assign capture     = (state_q == ST_IDLE) && req_i;
  assign track       = (state_q == ST_IDLE) && !req_i;
  assign restore     = (state_q == ST_RST);
  assign timer_start = (state_q == ST_GATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      prst_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      prst_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) state_q <= ST_GATE;
        ST_GATE: begin
          go_q    <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (timer_hit) begin
          prst_q  <= 1'b1;
          state_q <= ST_RST;
        end
        ST_RST: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o       = go_q;
  assign path_rst_o = prst_q;
  assign done_o     = done_q;
endmodule

// File: rtl/tune_gate_seq.sv
`timescale 1ns/1ps
module tune_gate_seq #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic clk_en_i,
  output logic card_clk_en_o,
  output logic go_o,
  output logic path_rst_o,
  output logic done_o
);
  logic timer_start, timer_hit, track, capture, restore;

  tune_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .timer_hit   (timer_hit),
    .timer_start (timer_start),
    .track       (track),
    .capture     (capture),
    .restore     (restore),
    .go_o        (go_o),
    .path_rst_o  (path_rst_o),
    .done_o      (done_o)
  );

  tune_settle_timer #(.CYCLES(CYC_PER_US)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .hit   (timer_hit)
  );

  tune_clk_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .track    (track),
    .capture  (capture),
    .restore  (restore),
    .clk_en_i (clk_en_i),
    .clk_en_o (card_clk_en_o)
  );
endmodule

// File: rtl/tune_gate_seq_chk.sv
`timescale 1ns/1ps
module tune_gate_seq_chk #(
  parameter int CYC_PER_US = 100
) (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic clk_en_i,
  input logic card_clk_en_o,
  input logic go_o,
  input logic path_rst_o,
  input logic done_o
);
  localparam int CW = $clog2(CYC_PER_US + 2) + 1;

  logic          busy_c, saved_c, armed_c;
  logic [CW-1:0] since_go_c;
  logic          accept_c;

  assign accept_c = req_i && (!busy_c || done_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c     <= 1'b0;
      saved_c    <= 1'b0;
      armed_c    <= 1'b0;
      since_go_c <= '0;
    end else begin
      if (accept_c) begin
        busy_c  <= 1'b1;
        saved_c <= clk_en_i;
      end else if (done_o) begin
        busy_c  <= 1'b0;
      end
      if (go_o) begin
        armed_c    <= 1'b1;
        since_go_c <= '0;
      end else begin
        if (done_o) armed_c <= 1'b0;
        if (armed_c) since_go_c <= since_go_c + 1'b1;
      end
    end
  end

  // R4
  a_r4_go_single: assert property (@(posedge clk) disable iff (rst) go_o |=> !go_o);
  a_r4_go_gated: assert property (@(posedge clk) disable iff (rst) go_o |-> !card_clk_en_o);
  // R5
  a_r5_rst_single: assert property (@(posedge clk) disable iff (rst) path_rst_o |=> !path_rst_o);
  a_r5_rst_gated: assert property (@(posedge clk) disable iff (rst) path_rst_o |-> !card_clk_en_o);
  a_r5_rst_timing: assert property (@(posedge clk) disable iff (rst)
    path_rst_o |-> (armed_c && since_go_c == CW'(CYC_PER_US - 1)));
  // R6
  a_r6_done_follows: assert property (@(posedge clk) disable iff (rst) path_rst_o |=> done_o);
  a_r6_done_cause: assert property (@(posedge clk) disable iff (rst) done_o |-> $past(path_rst_o));
  a_r6_restore: assert property (@(posedge clk) disable iff (rst) done_o |-> (card_clk_en_o == saved_c));
  // R3
  a_r3_gate_on_accept: assert property (@(posedge clk) disable iff (rst) accept_c |=> !card_clk_en_o);
  // R8
  a_r8_no_extra_go: assert property (@(posedge clk) disable iff (rst) go_o |-> (busy_c && !armed_c));
endmodule

bind tune_gate_seq tune_gate_seq_chk #(.CYC_PER_US(CYC_PER_US)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .clk_en_i      (clk_en_i),
  .card_clk_en_o (card_clk_en_o),
  .go_o          (go_o),
  .path_rst_o    (path_rst_o),
  .done_o        (done_o)
);

// File: tb/tune_gate_seq_bench.sv
`timescale 1ns/1ps
module tune_gate_seq_bench;
  localparam int CYC = 100;

  logic clk = 1'b0;
  logic rst, req_i, clk_en_i;
  logic card_clk_en_o, go_o, path_rst_o, done_o;
  int   n_run = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  tune_gate_seq #(.CYC_PER_US(CYC)) u_tune_gate_seq (
    .clk(clk), .rst(rst), .req_i(req_i), .clk_en_i(clk_en_i),
    .card_clk_en_o(card_clk_en_o), .go_o(go_o),
    .path_rst_o(path_rst_o), .done_o(done_o)
  );

  // {clk_en at request, inject a request mid-wait}
  localparam logic [1:0] VEC [4] = '{2'b10, 2'b00, 2'b11, 2'b01};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  // outputs packed as {card_clk_en, go, path_rst, done}
  function automatic logic [3:0] outs();
    return {card_clk_en_o, go_o, path_rst_o, done_o};
  endfunction

  // Runs one sequence from a sample point in idle; ends at the done sample point.
  task automatic run_seq(input logic en, input logic mid_req);
    logic ok;
    clk_en_i = en;
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    check("R3 gated after accept", outs(), 4'b0000);
    step();
    check("R4 go pulse", outs(), 4'b0100);
    ok = 1'b1;
    for (int j = 1; j <= CYC; j++) begin
      req_i = (mid_req && j == 5);
      step();
      if (j < CYC && outs() !== 4'b0000) ok = 1'b0;
      if (j == CYC) check("R5 path reset timing", outs(), 4'b0010);
    end
    req_i = 1'b0;
    check(mid_req ? "R8 busy request ignored" : "R5 quiet settling", {3'b000, ok}, 4'b0001);
    step();
    check(en ? "R6 done and restore" : "R7 stays off at done", outs(), {en, 3'b001});
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_i = 1'b0; clk_en_i = 1'b1;
    step(); step();
    check("R1 reset state", outs(), 4'b0000);
    rst = 1'b0;
    check("R1 first cycle after reset", outs(), 4'b0000);
    step();
    check("R2 tracks enable high", outs(), 4'b1000);
    clk_en_i = 1'b0;
    step();
    check("R2 tracks enable low", outs(), 4'b0000);

    foreach (VEC[i]) begin
      run_seq(VEC[i][1], VEC[i][0]);
      step();
      check("R6 done single cycle", outs(), {VEC[i][1], 3'b000});
      step();
    end

    // R9: request held high in the done cycle
    run_seq(1'b1, 1'b0);
    clk_en_i = 1'b0;
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    clk_en_i = 1'b1;
    check("R9 regated after done-cycle request", outs(), 4'b0000);
    step();
    check("R9 go for second sequence", outs(), 4'b0100);
    for (int j = 1; j <= CYC; j++) step();
    check("R9 second path reset", outs(), 4'b0010);
    step();
    check("R9 second restore uses new capture", outs(), 4'b0001);
    step();
    check("R2 tracking resumes", outs(), 4'b1000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule